// File: doc/BRIEF.md
# SPI Passthrough Opcode Filter with Address and Payload Bit Override

This block sits inline on a single-lane SPI link between an upstream host and a downstream serial flash. It watches every transaction bit by bit. Once the first byte (the opcode) is complete, it looks the opcode up in a 256-bit block map. If the opcode's bit is set, it forces the downstream chip select inactive for the rest of the transaction, so the flash never executes the command. For opcodes that it passes, a small table of command slots gives per-opcode attributes: the address length and whether the address and the leading payload bits may be rewritten.

Rewriting is done on the fly with mask/data merging. Each address bit whose mask bit is set is sent downstream as the matching data bit. The same merge applies to the first four payload bytes, using a separate 32-bit mask/data pair: word bits [7:0] cover the first payload byte, [15:8] the second, and so on up to [31:24]. The merge is a pure bit-serial multiplexer on the data line, so it adds no SCK latency. Address and payload bits travel most significant bit first within each byte.

The block runs on a system clock that oversamples the SPI pins. The SPI inputs are synchronous to that clock, and SCK stays high and low for at least one clock each. Only SPI mode 0 is supported: data is sampled on the SCK rising edge.

Top module: `spi_pt_filter`

## Requirements
- R1: When bit N of `filter_map` is set and a transaction's opcode is N, `dn_csb` stays low for the eight opcode bits. It goes high by the second system clock edge after the 8th SCK rising edge and stays high until `up_csb` rises.
- R2: When the opcode's bit in `filter_map` is clear, `dn_csb` equals `up_csb` for the whole transaction.
- R3: A block ends when `up_csb` goes high. The following transaction is judged only on its own opcode.
- R4: For an opcode matched by a valid slot with address override enabled, each address bit whose `addr_mask` bit is set is sent as the corresponding `addr_data` bit. All other address bits pass unchanged. For example, mask and data 0x0010_0000 force address bit 20 to 1.
- R5: With address override disabled in the matching slot, address bits pass unchanged.
- R6: The slot address mode code selects the address length and the bit numbering used by the override:
  - 0: no address.
  - 1: 24 bits, numbered [23:0].
  - 2: 32 bits, numbered [31:0].
  - 3: 32 bits when `cfg_addr4b` is 1 at opcode completion, otherwise 24 bits.
- R7: For a slot with payload override enabled, the payload begins right after the address. Within payload byte b (b = 0..3), the bit sent j-th (j = 0..7, MSB first) is replaced by `pay_data[8b+7-j]` when `pay_mask[8b+7-j]` is set.
- R8: Payload bytes after the fourth are never changed. No payload bit is changed when the slot's payload override is disabled.
- R9: An opcode that matches no valid slot is treated as a single-lane command with host-to-device payload. No address phase is assumed, and every bit after the opcode passes unchanged.
- R10: Opcode bits always pass unchanged. `dn_sck` follows `up_sck`. The data path adds no clock or SCK delay.
- R11: When several valid slots carry the same opcode, the lowest-indexed one supplies the attributes. Slots with the valid bit clear never match.
- R12: During and right after reset, `dn_csb` follows `up_csb` and `dn_mosi` follows `up_mosi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_map | input | 256 | One block bit per opcode value |
| slot_opcode | input | 8*NUM_SLOTS | Opcode of each command slot, slot i at [8i+7:8i] |
| slot_valid | input | NUM_SLOTS | Slot valid bits |
| slot_addr_mode | input | 2*NUM_SLOTS | Address mode code per slot (see R6) |
| slot_addr_swap | input | NUM_SLOTS | Address override enable per slot |
| slot_pay_swap | input | NUM_SLOTS | Payload override enable per slot |
| cfg_addr4b | input | 1 | Address width choice for mode code 3 |
| addr_mask | input | 32 | Address bits to replace |
| addr_data | input | 32 | Replacement address bit values |
| pay_mask | input | 32 | Payload bits to replace, little endian by byte |
| pay_data | input | 32 | Replacement payload bit values |
| up_sck | input | 1 | Host serial clock |
| up_csb | input | 1 | Host chip select, active low |
| up_mosi | input | 1 | Host data out |
| dn_sck | output | 1 | Serial clock to the flash |
| dn_csb | output | 1 | Chip select to the flash, active low |
| dn_mosi | output | 1 | Data to the flash after override |

## Verification
Every bit position in the bench is tied to one expected downstream value, so a phase counter that is off by one appears on `dn_mosi` as an override landing on the wrong bit. That bit sits in the first address or payload byte that carries a masked bit. A block flag that is set too early drops `dn_csb` before the opcode ends; a flag that survives `up_csb` rising shows `dn_csb` high during the first bit of the next transaction. Wrong address lengths or slot priority are caught by the position of the overridden bits, not only by their values.

// File: rtl/spi_pt_pkg.sv
package spi_pt_pkg;

    localparam int OP_BITS   = 8;
    localparam int ADDR_MAX  = 32;
    localparam int ADDR_3B   = 24;
    localparam int PAY_BYTES = 4;
    localparam int PAY_BITS  = PAY_BYTES * 8;
    localparam int CNT_W     = $clog2(ADDR_MAX) + 1;
    localparam int IDX_W     = $clog2(ADDR_MAX);

    localparam logic [1:0] AM_NONE = 2'd0;
    localparam logic [1:0] AM_3B   = 2'd1;
    localparam logic [1:0] AM_4B   = 2'd2;
    localparam logic [1:0] AM_CFG  = 2'd3;

    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_ADDR = 2'd1,
        PH_PAY  = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic             hit;
        logic [CNT_W-1:0] alen;
        logic             aswap;
        logic             pswap;
    } cmd_attr_t;

endpackage

// File: rtl/spi_pt_decode.sv
module spi_pt_decode
    import spi_pt_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic [OP_BITS-1:0]           opcode,
    input  logic [NUM_SLOTS*OP_BITS-1:0] slot_opcode,
    input  logic [NUM_SLOTS-1:0]         slot_valid,
    input  logic [NUM_SLOTS*2-1:0]       slot_addr_mode,
    input  logic [NUM_SLOTS-1:0]         slot_addr_swap,
    input  logic [NUM_SLOTS-1:0]         slot_pay_swap,
    input  logic                         cfg_addr4b,
    output cmd_attr_t                    attr
);

    logic [NUM_SLOTS-1:0]     hit;
    logic [CNT_W-1:0]         len [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g] = slot_valid[g] && (slot_opcode[g*OP_BITS +: OP_BITS] == opcode);

        always_comb begin
            unique case (slot_addr_mode[g*2 +: 2])
                AM_NONE: len[g] = '0;
                AM_3B:   len[g] = CNT_W'(ADDR_3B);
                AM_4B:   len[g] = CNT_W'(ADDR_MAX);
                default: len[g] = cfg_addr4b ? CNT_W'(ADDR_MAX) : CNT_W'(ADDR_3B);
            endcase
        end
    end

    // Walk from the highest slot down so the lowest matching index wins.
    always_comb begin
        attr = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                attr.hit   = 1'b1;
                attr.alen  = len[i];
                attr.aswap = slot_addr_swap[i];
                attr.pswap = slot_pay_swap[i];
            end
        end
    end

endmodule

// File: rtl/spi_pt_seq.sv
module spi_pt_seq
    import spi_pt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_sck,
    input  logic                up_csb,
    input  logic                up_mosi,
    input  logic [255:0]        filter_map,
    input  cmd_attr_t           attr_in,
    output logic [OP_BITS-1:0]  op_cand,
    output phase_e              ph_q,
    output logic [CNT_W-1:0]    cnt_q,
    output cmd_attr_t           attr_q,
    output logic                blk_q
);

    typedef struct packed {
        logic               sck;
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [OP_BITS-2:0] shf;
        cmd_attr_t          attr;
        logic               blk;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    rise;

    assign rise    = up_sck & ~st_q.sck;
    assign op_cand = {st_q.shf, up_mosi};

    always_comb begin
        st_d     = st_q;
        st_d.sck = up_sck;
        if (up_csb) begin
            st_d.ph   = PH_OP;
            st_d.cnt  = '0;
            st_d.shf  = '0;
            st_d.attr = '0;
            st_d.blk  = 1'b0;
        end else if (rise) begin
            unique case (st_q.ph)
                PH_OP: begin
                    st_d.shf = op_cand[OP_BITS-2:0];
                    if (st_q.cnt == CNT_W'(OP_BITS - 1)) begin
                        st_d.attr = attr_in;
                        st_d.blk  = filter_map[op_cand];
                        st_d.cnt  = '0;
                        st_d.ph   = (attr_in.alen != '0) ? PH_ADDR : PH_PAY;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_ADDR: begin
                    if (st_q.cnt == st_q.attr.alen - CNT_W'(1)) begin
                        st_d.cnt = '0;
                        st_d.ph  = PH_PAY;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_PAY: begin
                    if (st_q.cnt == CNT_W'(PAY_BITS - 1)) begin
                        st_d.cnt = '0;
                        st_d.ph  = PH_TAIL;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_q   = st_q.ph;
    assign cnt_q  = st_q.cnt;
    assign attr_q = st_q.attr;
    assign blk_q  = st_q.blk;

    // R1
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && !up_csb) |=> blk_q);

    // R1
    blk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_q) |-> ($past(ph_q) == PH_OP && $past(cnt_q) == CNT_W'(OP_BITS - 1)));

    // R3
    csb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_csb |=> (ph_q == PH_OP && cnt_q == '0 && !blk_q));

    // R6
    addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ADDR) |-> (cnt_q < attr_q.alen &&
            (attr_q.alen == CNT_W'(ADDR_3B) || attr_q.alen == CNT_W'(ADDR_MAX))));

endmodule

// File: rtl/spi_pt_merge.sv
module spi_pt_merge
    import spi_pt_pkg::*;
(
    input  phase_e              ph,
    input  logic [CNT_W-1:0]    cnt,
    input  cmd_attr_t           attr,
    input  logic [ADDR_MAX-1:0] addr_mask,
    input  logic [ADDR_MAX-1:0] addr_data,
    input  logic [PAY_BITS-1:0] pay_mask,
    input  logic [PAY_BITS-1:0] pay_data,
    output logic                ovr_en,
    output logic                ovr_bit
);

    logic [CNT_W-1:0] arel;
    logic [IDX_W-1:0] aidx;
    logic [4:0]       pidx;

    // Address bits go out MSB first: position cnt maps to bit alen-1-cnt.
    assign arel = attr.alen - CNT_W'(1) - cnt;
    assign aidx = arel[IDX_W-1:0];
    // Payload byte cnt/8 uses word byte cnt/8, MSB first inside the byte.
    assign pidx = {cnt[4:3], ~cnt[2:0]};

    always_comb begin
        ovr_en  = 1'b0;
        ovr_bit = 1'b0;
        unique case (ph)
            PH_ADDR: begin
                if (attr.hit && attr.aswap && !arel[CNT_W-1] && addr_mask[aidx]) begin
                    ovr_en  = 1'b1;
                    ovr_bit = addr_data[aidx];
                end
            end
            PH_PAY: begin
                if (attr.hit && attr.pswap && !cnt[CNT_W-1] && pay_mask[pidx]) begin
                    ovr_en  = 1'b1;
                    ovr_bit = pay_data[pidx];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_pt_filter.sv
module spi_pt_filter
    import spi_pt_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [255:0]                 filter_map,
    input  logic [NUM_SLOTS*OP_BITS-1:0] slot_opcode,
    input  logic [NUM_SLOTS-1:0]         slot_valid,
    input  logic [NUM_SLOTS*2-1:0]       slot_addr_mode,
    input  logic [NUM_SLOTS-1:0]         slot_addr_swap,
    input  logic [NUM_SLOTS-1:0]         slot_pay_swap,
    input  logic                         cfg_addr4b,
    input  logic [ADDR_MAX-1:0]          addr_mask,
    input  logic [ADDR_MAX-1:0]          addr_data,
    input  logic [PAY_BITS-1:0]          pay_mask,
    input  logic [PAY_BITS-1:0]          pay_data,
    input  logic                         up_sck,
    input  logic                         up_csb,
    input  logic                         up_mosi,
    output logic                         dn_sck,
    output logic                         dn_csb,
    output logic                         dn_mosi
);

    logic [OP_BITS-1:0] op_cand;
    cmd_attr_t          attr_lu;
    cmd_attr_t          attr_q;
    phase_e             ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               blk_q;
    logic               ovr_en;
    logic               ovr_bit;

    spi_pt_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
        .opcode         (op_cand),
        .slot_opcode    (slot_opcode),
        .slot_valid     (slot_valid),
        .slot_addr_mode (slot_addr_mode),
        .slot_addr_swap (slot_addr_swap),
        .slot_pay_swap  (slot_pay_swap),
        .cfg_addr4b     (cfg_addr4b),
        .attr           (attr_lu)
    );

    spi_pt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_sck     (up_sck),
        .up_csb     (up_csb),
        .up_mosi    (up_mosi),
        .filter_map (filter_map),
        .attr_in    (attr_lu),
        .op_cand    (op_cand),
        .ph_q       (ph_q),
        .cnt_q      (cnt_q),
        .attr_q     (attr_q),
        .blk_q      (blk_q)
    );

    spi_pt_merge u_merge (
        .ph        (ph_q),
        .cnt       (cnt_q),
        .attr      (attr_q),
        .addr_mask (addr_mask),
        .addr_data (addr_data),
        .pay_mask  (pay_mask),
        .pay_data  (pay_data),
        .ovr_en    (ovr_en),
        .ovr_bit   (ovr_bit)
    );

    assign dn_sck  = up_sck;
    assign dn_csb  = up_csb | blk_q;
    assign dn_mosi = (!up_csb && ovr_en) ? ovr_bit : up_mosi;

    // R10
    ovr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |-> (ph_q == PH_ADDR || ph_q == PH_PAY));

    // R8
    pay_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_PAY) |-> (cnt_q < CNT_W'(PAY_BITS)));

    // R9
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_OP && !attr_q.hit) |-> !ovr_en);

endmodule

// File: tb/spi_pt_filter_tb.sv
module spi_pt_filter_tb;

    localparam int CLK_P = 10;
    localparam int NS    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [255:0]  filter_map;
    logic [NS*8-1:0] slot_opcode;
    logic [NS-1:0] slot_valid;
    logic [NS*2-1:0] slot_addr_mode;
    logic [NS-1:0] slot_addr_swap;
    logic [NS-1:0] slot_pay_swap;
    logic          cfg_addr4b;
    logic [31:0]   addr_mask, addr_data, pay_mask, pay_data;
    logic          up_sck, up_csb, up_mosi;
    logic          dn_sck, dn_csb, dn_mosi;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_pt_filter #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .filter_map(filter_map),
        .slot_opcode(slot_opcode), .slot_valid(slot_valid),
        .slot_addr_mode(slot_addr_mode), .slot_addr_swap(slot_addr_swap),
        .slot_pay_swap(slot_pay_swap), .cfg_addr4b(cfg_addr4b),
        .addr_mask(addr_mask), .addr_data(addr_data),
        .pay_mask(pay_mask), .pay_data(pay_data),
        .up_sck(up_sck), .up_csb(up_csb), .up_mosi(up_mosi),
        .dn_sck(dn_sck), .dn_csb(dn_csb), .dn_mosi(dn_mosi)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input logic [7:0] op, input logic v,
                            input logic [1:0] mode, input logic as, input logic ps);
        slot_opcode[i*8 +: 8]  = op;
        slot_valid[i]          = v;
        slot_addr_mode[i*2 +: 2] = mode;
        slot_addr_swap[i]      = as;
        slot_pay_swap[i]       = ps;
    endtask

    // One transaction; expected downstream stream built from the requirements.
    task automatic xfer(input string req, input logic [7:0] op, input int alen,
                        input logic [31:0] addr, input int npay, input logic [63:0] pay,
                        input logic blk, input logic aswap, input logic pswap);
        logic [199:0] tx, ex;
        logic [31:0]  madr;
        logic [7:0]   pb, mb, bm, bd;
        int n = 0;
        madr = aswap ? ((addr & ~addr_mask) | (addr_data & addr_mask)) : addr;
        for (int i = 7; i >= 0; i--) begin tx[n] = op[i]; ex[n] = op[i]; n++; end
        for (int i = alen - 1; i >= 0; i--) begin tx[n] = addr[i]; ex[n] = madr[i]; n++; end
        for (int b = 0; b < npay; b++) begin
            pb = pay[8*b +: 8];
            mb = pb;
            if (pswap && b < 4) begin
                bm = pay_mask[8*b +: 8];
                bd = pay_data[8*b +: 8];
                mb = (pb & ~bm) | (bd & bm);
            end
            for (int i = 7; i >= 0; i--) begin tx[n] = pb[i]; ex[n] = mb[i]; n++; end
        end
        @(negedge clk);
        up_csb = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            up_sck  = 1'b0;
            up_mosi = tx[k];
            repeat (2) @(negedge clk);
            chk(blk ? "R1" : "R2", $sformatf("csb low half bit %0d", k), 32'(dn_csb), 32'(blk && k >= 8));
            if (!(blk && k >= 8))
                chk(req, $sformatf("mosi bit %0d", k), 32'(dn_mosi), 32'(ex[k]));
            chk("R10", "sck low", 32'(dn_sck), 32'd0);
            up_sck = 1'b1;
            repeat (2) @(negedge clk);
            chk(blk ? "R1" : "R2", $sformatf("csb high half bit %0d", k), 32'(dn_csb), 32'(blk && k >= 7));
        end
        up_sck = 1'b0;
        repeat (2) @(negedge clk);
        up_csb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", "csb after end", 32'(dn_csb), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; up_csb = 1'b0; up_mosi = 1'b1; up_sck = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12", "csb in reset", 32'(dn_csb), 32'd0);
        chk("R12", "mosi in reset", 32'(dn_mosi), 32'd1);
        up_csb = 1'b1; up_mosi = 1'b0;
        @(negedge clk);
        chk("R12", "csb idle", 32'(dn_csb), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12", "csb after reset", 32'(dn_csb), 32'd1);
        chk("R12", "mosi after reset", 32'(dn_mosi), 32'd0);
    endtask

    task automatic t_filter();
        // R1 blocked opcodes, then R3 next transaction passes
        xfer("R1", 8'h05, 0, 0, 3, 64'h00C3_5A, 1'b1, 1'b0, 1'b0);
        xfer("R3", 8'h9F, 0, 0, 2, 64'h55AA, 1'b0, 1'b0, 1'b0);
        xfer("R1", 8'hFF, 0, 0, 1, 64'h12, 1'b1, 1'b0, 1'b0);
        xfer("R2", 8'h04, 0, 0, 0, 64'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_addr3();
        addr_mask = 32'h0010_0000; addr_data = 32'h0010_0000;
        // R4 bit 20 forced high in a 24-bit address
        xfer("R4", 8'h03, 24, 32'h0001_2345, 2, 64'hF00F, 1'b0, 1'b1, 1'b0);
        addr_mask = 32'h00F0_0F01; addr_data = 32'h00A0_0500;
        xfer("R4", 8'h03, 24, 32'h00FF_FFFF, 1, 64'h81, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_addr4();
        addr_mask = 32'hF000_000F; addr_data = 32'hA000_0005;
        // R6 32-bit address mode with payload override after it (R7)
        xfer("R6", 8'h13, 32, 32'h1234_5678, 5, 64'h66_5544_3322, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_addr_cfg();
        addr_mask = 32'h8080_0001; addr_data = 32'h0080_0001;
        cfg_addr4b = 1'b1;
        xfer("R6", 8'h0B, 32, 32'hF0F0_F0F0, 1, 64'h3C, 1'b0, 1'b1, 1'b0);
        cfg_addr4b = 1'b0;
        xfer("R6", 8'h0B, 24, 32'h00F0_F0F0, 1, 64'h3C, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_payload();
        pay_mask = 32'h0000_0023; pay_data = 32'h0000_0022;
        // R7 bit0->0, bit1->1, bit5->1 in the first byte
        xfer("R7", 8'h01, 0, 0, 2, 64'h0001, 1'b0, 1'b0, 1'b1);
        pay_mask = 32'h8100_FF23; pay_data = 32'h0100_5A22;
        // R8 bytes 4 and 5 untouched
        xfer("R8", 8'h01, 0, 0, 6, 64'hFFFF_FFFF_0000_FFFF, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_noswap();
        addr_mask = 32'hFFFF_FFFF; addr_data = 32'h0;
        pay_mask  = 32'hFFFF_FFFF; pay_data  = 32'h0;
        // R5 and R8 with overrides disabled in the slot
        xfer("R5", 8'h02, 24, 32'h00AB_CDEF, 2, 64'hFFFF, 1'b0, 1'b0, 1'b0);
        // R9 unmatched opcode passes everything
        xfer("R9", 8'h9F, 0, 0, 5, 64'hFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        addr_mask = 32'h0000_00FF; addr_data = 32'h0000_005A;
        // R11 slot 0 beats slot 5 for opcode 03h
        xfer("R11", 8'h03, 24, 32'h0012_3400, 1, 64'h11, 1'b0, 1'b1, 1'b0);
        // R11 invalid slot 6 ignored, slot 7 (24-bit, override) used
        xfer("R11", 8'h44, 24, 32'h00C0_FFEE, 1, 64'h22, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        filter_map = '0;
        filter_map[8'h05] = 1'b1;
        filter_map[8'hFF] = 1'b1;
        slot_opcode = '0; slot_valid = '0; slot_addr_mode = '0;
        slot_addr_swap = '0; slot_pay_swap = '0;
        set_slot(0, 8'h03, 1'b1, 2'd1, 1'b1, 1'b0);
        set_slot(1, 8'h13, 1'b1, 2'd2, 1'b1, 1'b1);
        set_slot(2, 8'h0B, 1'b1, 2'd3, 1'b1, 1'b0);
        set_slot(3, 8'h01, 1'b1, 2'd0, 1'b0, 1'b1);
        set_slot(4, 8'h02, 1'b1, 2'd1, 1'b0, 1'b0);
        set_slot(5, 8'h03, 1'b1, 2'd1, 1'b0, 1'b0);
        set_slot(6, 8'h44, 1'b0, 2'd2, 1'b1, 1'b0);
        set_slot(7, 8'h44, 1'b1, 2'd1, 1'b1, 1'b0);
        cfg_addr4b = 1'b0;
        addr_mask = '0; addr_data = '0; pay_mask = '0; pay_data = '0;
        t_reset();
        t_filter();
        t_addr3();
        t_addr4();
        t_addr_cfg();
        t_payload();
        t_noswap();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule